// File: doc/BRIEF.md
# Staggered Instruction Distribution Line

This block hands a single instruction stream to a row of processing elements. Every element receives the same instructions in the same order. The difference is when each one arrives. Each element past the first has its own delay stage and a two-way selector. The selector either takes the word that has just passed through the neighbour's delay stage, or takes the live broadcast word and so starts a new delay chain. Arrival times therefore form a sawtooth over the array. Each element lags the broadcast by its index modulo a run-time distance k.

Software writes k through a load strobe. The new value is held pending and only replaces the active one when the line is empty. That means no delay stage holds a valid word and the broadcast is idle. This way no instruction is ever split across two patterns. Slots without a valid instruction show a fixed no-operation word with the valid bit low.

Top module: `instr_stagger_line`

## Requirements
- R1: After reset every element output shows valid low and the no-operation word (default all zeros), and the active distance equals the element count, so the full chain is in use.
- R2: Element 0 shows the broadcast word and its valid bit in the same cycle they are driven, with no delay stage.
- R3: With active distance k, a word broadcast in cycle c appears at element n, valid for exactly one cycle, in cycle c + (n mod k).
- R4: With k = 1 every element shows each broadcast word in the cycle it is driven.
- R5: With k equal to the element count, element n lags by n cycles, and the last element lags by count minus one.
- R6: Words broadcast in consecutive cycles reach each element in consecutive cycles, in broadcast order, with no loss or repeat.
- R7: In any cycle where an element has no valid word, its valid bit is low and its instruction output equals the no-operation word. This holds for gaps inside a stream as well.
- R8: A distance loaded while any delay stage holds a valid word, or while the broadcast is valid, stays pending. Words in flight and words broadcast before the drain keep the old pattern. The new distance becomes active at the first clock edge at which the line is empty.
- R9: A loaded distance of 0 is used as 1, and a loaded distance above the element count is used as the element count.
- R10: If the distance is loaded more than once before it takes effect, the last loaded value is the one that becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bcast_insn | input | INSN_W | Broadcast instruction word |
| bcast_vld | input | 1 | Broadcast word is valid this cycle |
| cfg_dist | input | KW | Neighbourhood distance to load |
| cfg_load | input | 1 | Load strobe for cfg_dist |
| pe_insn | output | NUM_PE*INSN_W | Instruction per element, element n in bits n*INSN_W upward |
| pe_vld | output | NUM_PE | Valid bit per element |

## Verification
The hardest situation to reach is a distance load that arrives while words are still moving down the chain. Reaching it also requires showing that those words, and words broadcast after the load but before the drain, still follow the old sawtooth. The stimulus asserts the load strobe in the same cycle as the first of a pair of broadcast words. The line is then busy on both the edge that captures the request and the following one. Every element is checked against the old lags. An idle gap follows, and a fresh probe checks the new lags. Zero and out-of-range loads, and back-to-back loads, are reached by driving the load strobe with those values while idle.

// File: rtl/stagger_pkg.sv
package stagger_pkg;

    // Source of an element's instruction: its own delay stage or the live broadcast.
    typedef enum logic {
        SRC_CHAIN = 1'b0,
        SRC_BCAST = 1'b1
    } src_sel_e;

    // Restrict a requested distance to the legal range 1 .. max_k.
    function automatic int unsigned clamp_dist(input int unsigned req, input int unsigned max_k);
        if (req == 0)
            return 1;
        else if (req > max_k)
            return max_k;
        else
            return req;
    endfunction

endpackage

// File: rtl/stagger_cfg.sv
module stagger_cfg
    import stagger_pkg::*;
#(
    parameter int NUM_PE = 16,
    parameter int KW     = $clog2(NUM_PE + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_load,
    input  logic [KW-1:0]     cfg_dist,
    input  logic              chain_busy,
    input  logic              bcast_vld,
    output logic [KW-1:0]     k_active,
    output src_sel_e          src_sel [NUM_PE]
);

    typedef struct packed {
        logic [KW-1:0] k;
        logic [KW-1:0] pend_k;
        logic          pend_vld;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       line_idle;

    assign line_idle = !chain_busy && !bcast_vld;

    always_comb begin
        st_d = st_q;
        if (st_q.pend_vld && line_idle) begin
            st_d.k        = st_q.pend_k;
            st_d.pend_vld = 1'b0;
        end
        if (cfg_load) begin
            st_d.pend_k   = KW'(clamp_dist(int'(cfg_dist), NUM_PE));
            st_d.pend_vld = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.k        <= KW'(NUM_PE);
            st_q.pend_k   <= KW'(NUM_PE);
            st_q.pend_vld <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign k_active = st_q.k;

    always_comb begin
        for (int n = 0; n < NUM_PE; n++) begin
            src_sel[n] = ((n % int'(st_q.k)) == 0) ? SRC_BCAST : SRC_CHAIN;
        end
    end

endmodule

// File: rtl/stagger_stage.sv
module stagger_stage
    import stagger_pkg::*;
#(
    parameter int              INSN_W   = 32,
    parameter logic [INSN_W-1:0] NOP_WORD = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INSN_W-1:0] up_insn,
    input  logic              up_vld,
    input  logic [INSN_W-1:0] bcast_insn,
    input  logic              bcast_vld,
    input  src_sel_e          sel,
    output logic [INSN_W-1:0] out_insn,
    output logic              out_vld,
    output logic              held_vld
);

    typedef struct packed {
        logic [INSN_W-1:0] insn;
        logic              vld;
    } slot_t;

    slot_t hold_d, hold_q;

    always_comb begin
        hold_d.insn = up_insn;
        hold_d.vld  = up_vld;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q.insn <= NOP_WORD;
            hold_q.vld  <= 1'b0;
        end else begin
            hold_q <= hold_d;
        end
    end

    always_comb begin
        if (sel == SRC_BCAST) begin
            out_vld  = bcast_vld;
            out_insn = bcast_vld ? bcast_insn : NOP_WORD;
        end else begin
            out_vld  = hold_q.vld;
            out_insn = hold_q.vld ? hold_q.insn : NOP_WORD;
        end
    end

    assign held_vld = hold_q.vld;

endmodule

// File: rtl/instr_stagger_line.sv
module instr_stagger_line
    import stagger_pkg::*;
#(
    parameter int              NUM_PE   = 16,
    parameter int              INSN_W   = 32,
    parameter logic [INSN_W-1:0] NOP_WORD = '0,
    parameter int              KW       = $clog2(NUM_PE + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [INSN_W-1:0]        bcast_insn,
    input  logic                     bcast_vld,
    input  logic [KW-1:0]            cfg_dist,
    input  logic                     cfg_load,
    output logic [NUM_PE*INSN_W-1:0] pe_insn,
    output logic [NUM_PE-1:0]        pe_vld
);

    logic [INSN_W-1:0] lane_insn [NUM_PE];
    logic [NUM_PE-1:0] lane_vld;
    logic [NUM_PE-1:0] stage_busy;
    logic [KW-1:0]     k_active;
    src_sel_e          src_sel [NUM_PE];
    logic              chain_busy;

    assign chain_busy = |stage_busy;

    stagger_cfg #(
        .NUM_PE (NUM_PE),
        .KW     (KW)
    ) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_load),
        .cfg_dist   (cfg_dist),
        .chain_busy (chain_busy),
        .bcast_vld  (bcast_vld),
        .k_active   (k_active),
        .src_sel    (src_sel)
    );

    // Element 0 always follows the broadcast directly.
    assign lane_vld[0]   = bcast_vld;
    assign lane_insn[0]  = bcast_vld ? bcast_insn : NOP_WORD;
    assign stage_busy[0] = 1'b0;

    for (genvar n = 1; n < NUM_PE; n++) begin : g_stage
        stagger_stage #(
            .INSN_W   (INSN_W),
            .NOP_WORD (NOP_WORD)
        ) u_stage (
            .clk        (clk),
            .rst_n      (rst_n),
            .up_insn    (lane_insn[n-1]),
            .up_vld     (lane_vld[n-1]),
            .bcast_insn (bcast_insn),
            .bcast_vld  (bcast_vld),
            .sel        (src_sel[n]),
            .out_insn   (lane_insn[n]),
            .out_vld    (lane_vld[n]),
            .held_vld   (stage_busy[n])
        );
    end

    for (genvar n = 0; n < NUM_PE; n++) begin : g_out
        assign pe_insn[n*INSN_W +: INSN_W] = lane_insn[n];
    end
    assign pe_vld = lane_vld;

endmodule

// File: rtl/instr_stagger_line_chk.sv
module instr_stagger_line_chk #(
    parameter int              NUM_PE   = 16,
    parameter int              INSN_W   = 32,
    parameter logic [INSN_W-1:0] NOP_WORD = '0,
    parameter int              KW       = $clog2(NUM_PE + 1)
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [INSN_W-1:0]        bcast_insn,
    input logic                     bcast_vld,
    input logic [NUM_PE*INSN_W-1:0] pe_insn,
    input logic [NUM_PE-1:0]        pe_vld,
    input logic [KW-1:0]            k_active,
    input logic                     chain_busy
);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    // R9
    k_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (k_active >= KW'(1)) && (k_active <= KW'(NUM_PE)));

    // R8
    k_drained_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$stable(k_active)) |-> ($past(!chain_busy) && $past(!bcast_vld)));

    for (genvar n = 0; n < NUM_PE; n++) begin : g_lane
        // R7
        nop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !pe_vld[n] |-> (pe_insn[n*INSN_W +: INSN_W] == NOP_WORD));

        // R3
        restart_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
            ((n % int'(k_active)) == 0) |->
                ((pe_vld[n] == bcast_vld) &&
                 (!bcast_vld || pe_insn[n*INSN_W +: INSN_W] == bcast_insn)));

        if (n > 0) begin : g_chain
            // R6
            chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (past_ok && (n % int'(k_active)) != 0) |->
                    ((pe_vld[n] == $past(pe_vld[n-1])) &&
                     (pe_insn[n*INSN_W +: INSN_W] == $past(pe_insn[(n-1)*INSN_W +: INSN_W]))));
        end
    end

endmodule

bind instr_stagger_line instr_stagger_line_chk #(
    .NUM_PE   (NUM_PE),
    .INSN_W   (INSN_W),
    .NOP_WORD (NOP_WORD),
    .KW       (KW)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bcast_insn (bcast_insn),
    .bcast_vld  (bcast_vld),
    .pe_insn    (pe_insn),
    .pe_vld     (pe_vld),
    .k_active   (k_active),
    .chain_busy (chain_busy)
);

// File: tb/instr_stagger_line_bench.sv
module instr_stagger_line_bench;

    localparam int NUM_PE = 16;
    localparam int INSN_W = 32;
    localparam int KW     = $clog2(NUM_PE + 1);
    localparam logic [INSN_W-1:0] NOP = '0;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [INSN_W-1:0]        bcast_insn;
    logic                     bcast_vld;
    logic [KW-1:0]            cfg_dist;
    logic                     cfg_load;
    logic [NUM_PE*INSN_W-1:0] pe_insn;
    logic [NUM_PE-1:0]        pe_vld;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    instr_stagger_line #(
        .NUM_PE (NUM_PE),
        .INSN_W (INSN_W)
    ) u_instr_stagger_line (
        .clk        (clk),
        .rst_n      (rst_n),
        .bcast_insn (bcast_insn),
        .bcast_vld  (bcast_vld),
        .cfg_dist   (cfg_dist),
        .cfg_load   (cfg_load),
        .pe_insn    (pe_insn),
        .pe_vld     (pe_vld)
    );

    function automatic int clampk(input int v);
        if (v == 0) return 1;
        if (v > NUM_PE) return NUM_PE;
        return v;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_k(input int v);
        @(posedge clk); #1;
        cfg_dist = KW'(v);
        cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_load = 1'b0;
        repeat (3) @(posedge clk);
    endtask

    // Broadcast len words (tag+i, slot i valid if mask[i]) and check every
    // element against lag (n mod k_exp). Optionally pulse a load in slot 0.
    task automatic probe(input int k_exp, input logic [INSN_W-1:0] tag, input int len,
                         input logic [7:0] mask, input bit do_load, input int load_v,
                         input string req);
        bit          ok [NUM_PE];
        int          bad_cyc [NUM_PE];
        int          hits [NUM_PE];
        int          want_hits;
        want_hits = 0;
        for (int i = 0; i < len; i++) if (mask[i]) want_hits++;
        for (int n = 0; n < NUM_PE; n++) begin
            ok[n] = 1'b1; bad_cyc[n] = -1; hits[n] = 0;
        end
        @(posedge clk); #1;
        for (int c = 0; c < len + NUM_PE + 1; c++) begin
            if (c < len) begin
                bcast_vld  = mask[c];
                bcast_insn = tag + INSN_W'(c);
            end else begin
                bcast_vld  = 1'b0;
                bcast_insn = 32'hDEAD_0000;
            end
            if (c == 0 && do_load) begin
                cfg_dist = KW'(load_v);
                cfg_load = 1'b1;
            end else begin
                cfg_load = 1'b0;
            end
            @(negedge clk);
            for (int n = 0; n < NUM_PE; n++) begin
                int j;
                bit ev;
                logic [INSN_W-1:0] ew;
                j  = c - (n % k_exp);
                ev = (j >= 0) && (j < len) && mask[j];
                ew = ev ? tag + INSN_W'(j) : NOP;
                if (pe_vld[n]) hits[n]++;
                if (pe_vld[n] !== ev || pe_insn[n*INSN_W +: INSN_W] !== ew) begin
                    if (ok[n]) bad_cyc[n] = c;
                    ok[n] = 1'b0;
                end
            end
            @(posedge clk); #1;
        end
        cfg_load = 1'b0;
        for (int n = 0; n < NUM_PE; n++) begin
            check(ok[n] && hits[n] == want_hits, req,
                  $sformatf("element %0d k=%0d tag=%h first bad cycle(actual)/lag(expected)", n, k_exp, tag),
                  bad_cyc[n], n % k_exp);
        end
    endtask

    task automatic t_reset;
        // R1: outputs idle with NOP after reset
        @(negedge clk);
        for (int n = 0; n < NUM_PE; n++) begin
            check(pe_vld[n] == 1'b0, "R1", $sformatf("valid element %0d", n), int'(pe_vld[n]), 0);
            check(pe_insn[n*INSN_W +: INSN_W] == NOP, "R1", $sformatf("word element %0d", n),
                  int'(pe_insn[n*INSN_W +: INSN_W]), int'(NOP));
        end
    endtask

    task automatic t_elem0;
        // R2: element 0 follows broadcast in the same cycle
        @(posedge clk); #1;
        bcast_insn = 32'h0000_5A5A; bcast_vld = 1'b1;
        #1;
        check(pe_vld[0] && pe_insn[INSN_W-1:0] == 32'h0000_5A5A, "R2", "element 0 same cycle",
              int'(pe_insn[INSN_W-1:0]), 32'h5A5A);
        @(negedge clk);
        @(posedge clk); #1;
        bcast_vld = 1'b0;
        repeat (NUM_PE + 2) @(posedge clk);
    endtask

    initial begin
        rst_n = 1'b0; bcast_insn = '0; bcast_vld = 1'b0; cfg_dist = '0; cfg_load = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        probe(NUM_PE, 32'h1000_0000, 1, 8'h01, 1'b0, 0, "R1 R5");
        t_elem0();
        set_k(4);
        probe(4, 32'h2000_0000, 1, 8'h01, 1'b0, 0, "R3");
        probe(4, 32'h2100_0000, 4, 8'h0F, 1'b0, 0, "R6");
        probe(4, 32'h2200_0000, 5, 8'h15, 1'b0, 0, "R7");
        set_k(1);
        probe(1, 32'h3000_0000, 3, 8'h07, 1'b0, 0, "R4");
        set_k(NUM_PE);
        probe(NUM_PE, 32'h4000_0000, 3, 8'h07, 1'b0, 0, "R5 R6");
        // R8: load while busy; old pattern kept for both words
        probe(NUM_PE, 32'h5000_0000, 2, 8'h03, 1'b1, 2, "R8 old");
        repeat (2) @(posedge clk);
        probe(2, 32'h5100_0000, 2, 8'h03, 1'b0, 0, "R8 new");
        set_k(0);
        probe(clampk(0), 32'h6000_0000, 1, 8'h01, 1'b0, 0, "R9 zero");
        set_k(20);
        probe(clampk(20), 32'h6100_0000, 1, 8'h01, 1'b0, 0, "R9 high");
        // R10: two loads back to back, last wins
        @(posedge clk); #1;
        cfg_dist = KW'(3); cfg_load = 1'b1;
        @(posedge clk); #1;
        cfg_dist = KW'(5);
        @(posedge clk); #1;
        cfg_load = 1'b0;
        repeat (3) @(posedge clk);
        probe(5, 32'h7000_0000, 2, 8'h03, 1'b0, 0, "R10 R3");
        done = 1'b1;
    end

    initial begin
        fork
            begin
                wait (done);
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule